// File: doc/BRIEF.md
# Combination Lock Controller with Wrong-Entry Lockout

This block is a clocked controller for a small combination lock. A user presents a 3-bit key together with a one-cycle entry strobe. The controller compares that key against a stored 3-bit secret. A match opens the lock. A mismatch reports a wrong entry and adds one to a count of consecutive failures.

A second equality check compares the failure count against a 3-bit limit that can be programmed. When the count reaches the limit, the controller latches a lockout state. Key entries do not move it out of that state; only reset does. The current state is brought out as a 2-bit code, and each state also has its own indication output.

Keypad scanning, debouncing and driving the lock mechanism are handled elsewhere. The block expects a clean, synchronous strobe.

Top module: `combo_lock`

## Requirements
- R1: Reset is synchronous and active-high. On the edge where `rst` is high, the state code becomes 00, the failure count becomes zero, and all three indications are low.
- R2: On an edge where `enter_i` is high, the state is not 11, and `key_i` equals `secret_i` on all three bits, the state code becomes 01.
- R3: On an edge where `enter_i` is high, the state is not 11, and `key_i` differs from `secret_i` in any bit, the failure count increases by one. The state code becomes 10 unless R4 applies.
- R4: If the failure count after a wrong entry equals the effective limit, the state code becomes 11 on that edge.
- R5: State 11 can only be left by reset. Entries of any key, matching or not, leave it at 11.
- R6: On an edge where `enter_i` is low, neither the state nor the failure count changes.
- R7: A `max_tries_i` value of 0 is treated as 1, so one wrong entry locks the controller out.
- R8: `open_o` is high only in state 01, `wrong_o` only in state 10, and `lockout_o` only in state 11. In state 00 all three are low.
- R9: A matching entry clears the failure count to zero. Only an unbroken run of wrong entries counts toward lockout.
- R10: The failure count saturates at 7 instead of wrapping to 0. If the limit is lowered below the current count, further wrong entries leave the state at 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_i | input | 1 | One-cycle strobe; the key is evaluated on this edge |
| key_i | input | 3 | Key being submitted |
| secret_i | input | 3 | Stored secret the key is compared with |
| max_tries_i | input | 3 | Consecutive wrong entries allowed before lockout (0 acts as 1) |
| open_o | output | 1 | High in the open state (01) |
| wrong_o | output | 1 | High in the wrong-entry state (10) |
| lockout_o | output | 1 | High in the lockout state (11) |
| state_o | output | 2 | Current state code |

## Verification
The bench enters keys that differ from the secret in exactly one bit position. A comparator that ignores that bit would open the lock where it should report a wrong entry. It runs failure sequences that are broken by a correct entry, which exposes a counter that is not cleared on a match and therefore locks out early. It programs a limit of 0, and checks that a limit which only compares against count 1 through 7 would never lock out. It lowers the limit below the current count and then keeps entering wrong keys: a counter that wraps would pass through the limit value and lock out, while a saturating one does not. It also sends matching keys while in lockout and toggles the strobe low between entries, to catch an FSM that escapes lockout or advances without a strobe.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_OPEN    = 2'b01,
    ST_WRONG   = 2'b10,
    ST_LOCKOUT = 2'b11
  } lock_state_e;
endpackage

// File: rtl/eq_cmp.sv
module eq_cmp #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  logic [W-1:0] diff;

  // per-bit difference, then a NOR across all bits
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = a[i] ^ b[i];
  end

  assign eq = ~(|diff);
endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next_inc
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign cnt_next_inc = sat_inc(cnt);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt_next_inc;
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import combo_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  logic        key_hit,
  input  logic        limit_hit,
  output lock_state_e state
);
  lock_state_e state_nx;

  always_comb begin
    state_nx = state;
    if (accept) begin
      if (key_hit)        state_nx = ST_OPEN;
      else if (limit_hit) state_nx = ST_LOCKOUT;
      else                state_nx = ST_WRONG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import combo_lock_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic [CODE_W-1:0] key_i,
  input  logic [CODE_W-1:0] secret_i,
  input  logic [CNT_W-1:0]  max_tries_i,
  output logic              open_o,
  output logic              wrong_o,
  output logic              lockout_o,
  output logic [1:0]        state_o
);
  // a programmed limit of zero behaves as one
  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? CNT_W'(1) : lim;
  endfunction

  lock_state_e      state;
  logic             accept;
  logic             key_hit;
  logic             limit_hit;
  logic             miss_evt;
  logic             hit_evt;
  logic [CNT_W-1:0] fail_cnt;
  logic [CNT_W-1:0] fail_cnt_inc;
  logic [CNT_W-1:0] limit_eff;

  assign accept    = enter_i && (state != ST_LOCKOUT);
  assign hit_evt   = accept && key_hit;
  assign miss_evt  = accept && !key_hit;
  assign limit_eff = eff_limit(max_tries_i);

  eq_cmp #(.W(CODE_W)) u_key_cmp (
    .a  (key_i),
    .b  (secret_i),
    .eq (key_hit)
  );

  eq_cmp #(.W(CNT_W)) u_limit_cmp (
    .a  (fail_cnt_inc),
    .b  (limit_eff),
    .eq (limit_hit)
  );

  fail_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .inc          (miss_evt),
    .clr          (hit_evt),
    .cnt          (fail_cnt),
    .cnt_next_inc (fail_cnt_inc)
  );

  lock_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .key_hit   (key_hit),
    .limit_hit (limit_hit),
    .state     (state)
  );

  assign state_o   = state;
  assign open_o    = (state == ST_OPEN);
  assign wrong_o   = (state == ST_WRONG);
  assign lockout_o = (state == ST_LOCKOUT);
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              enter_i,
  input logic [CODE_W-1:0] key_i,
  input logic [CODE_W-1:0] secret_i,
  input logic              open_o,
  input logic              wrong_o,
  input logic              lockout_o,
  input logic [1:0]        state_o,
  input logic              key_hit,
  input logic              limit_hit,
  input logic [CNT_W-1:0]  fail_cnt
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (state_o == 2'b00 && fail_cnt == '0));

  p_match_open_r2: assert property (@(posedge clk) disable iff (rst)
    (enter_i && state_o != 2'b11 && key_i == secret_i) |=> open_o);

  p_miss_count_r3: assert property (@(posedge clk) disable iff (rst)
    (enter_i && state_o != 2'b11 && key_i != secret_i && fail_cnt != '1)
      |=> (fail_cnt == $past(fail_cnt) + 1'b1));

  p_limit_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (enter_i && state_o != 2'b11 && !key_hit && limit_hit) |=> lockout_o);

  p_absorb_r5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b11) |=> (state_o == 2'b11));

  p_no_strobe_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !enter_i |=> ($stable(state_o) && $stable(fail_cnt)));

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({open_o, wrong_o, lockout_o}));

  p_match_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (enter_i && state_o != 2'b11 && key_hit) |=> (fail_cnt == '0));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (fail_cnt == '1) |=> (fail_cnt != '0 || $past(key_hit && enter_i)));
endmodule

bind combo_lock combo_lock_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .enter_i   (enter_i),
  .key_i     (key_i),
  .secret_i  (secret_i),
  .open_o    (open_o),
  .wrong_o   (wrong_o),
  .lockout_o (lockout_o),
  .state_o   (state_o),
  .key_hit   (key_hit),
  .limit_hit (limit_hit),
  .fail_cnt  (fail_cnt)
);

// File: tb/test_combo_lock.sv
module test_combo_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter_i = 1'b0;
  logic [2:0] key_i = '0;
  logic [2:0] secret_i = 3'b101;
  logic [2:0] max_tries_i = 3'd3;
  logic       open_o, wrong_o, lockout_o;
  logic [1:0] state_o;

  always #5 clk = ~clk;

  combo_lock i_combo_lock (
    .clk, .rst, .enter_i, .key_i, .secret_i, .max_tries_i,
    .open_o, .wrong_o, .lockout_o, .state_o
  );

  typedef struct {
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_bad  = 0;
  bit   done   = 0;
  logic [1:0] m_st  = 2'b00;
  logic [2:0] m_cnt = 3'd0;

  // reference model written from the requirements
  task automatic drive(input bit r, input bit en, input logic [2:0] k,
                       input logic [2:0] lim, input string tag);
    @(negedge clk);
    rst = r; enter_i = en; key_i = k; max_tries_i = lim;
    if (r) begin
      m_st = 2'b00; m_cnt = 3'd0;
    end else if (en && m_st != 2'b11) begin
      if (k == secret_i) begin
        m_st = 2'b01; m_cnt = 3'd0;
      end else begin
        logic [2:0] nc, el;
        nc = (m_cnt == 3'd7) ? 3'd7 : m_cnt + 3'd1;
        el = (lim == 3'd0) ? 3'd1 : lim;
        m_cnt = nc;
        m_st = (nc == el) ? 2'b11 : 2'b10;
      end
    end
    exp_q.push_back('{st: m_st, tag: tag});
  endtask

  // monitor: compare a little after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [2:0] flags_exp;
      e = exp_q.pop_front();
      flags_exp = {e.st == 2'b01, e.st == 2'b10, e.st == 2'b11};
      n_vec++;
      if (state_o !== e.st || {open_o, wrong_o, lockout_o} !== flags_exp) begin
        n_bad++;
        $display("FAIL %s: state=%b flags=%b expected state=%b flags=%b",
                 e.tag, state_o, {open_o, wrong_o, lockout_o}, e.st, flags_exp);
      end
    end
  end

  initial begin
    // R1 reset state
    drive(1, 0, 3'b000, 3'd3, "R1 reset");
    drive(1, 1, 3'b101, 3'd3, "R1 reset beats strobe");
    // R6 idle holds
    drive(0, 0, 3'b101, 3'd3, "R6 no strobe idle");
    // R2 match
    drive(0, 1, 3'b101, 3'd3, "R2 match opens");
    drive(0, 0, 3'b000, 3'd3, "R6 no strobe hold open");
    // R3 / R8 single-bit differences
    drive(0, 1, 3'b100, 3'd3, "R3 bit0 differs");
    drive(0, 1, 3'b111, 3'd3, "R3 bit1 differs");
    // R9 match clears count; then two more wrongs must not lock
    drive(0, 1, 3'b101, 3'd3, "R9 match clears");
    drive(0, 1, 3'b001, 3'd3, "R9 bit2 differs after clear");
    drive(0, 0, 3'b001, 3'd3, "R6 no strobe hold wrong");
    drive(0, 1, 3'b001, 3'd3, "R9 second wrong no lock");
    // R4 third consecutive wrong locks
    drive(0, 1, 3'b010, 3'd3, "R4 reach limit");
    // R5 absorbing
    drive(0, 1, 3'b101, 3'd3, "R5 match ignored in lockout");
    drive(0, 1, 3'b000, 3'd3, "R5 miss ignored in lockout");
    drive(0, 0, 3'b000, 3'd3, "R5 idle in lockout");
    drive(1, 0, 3'b000, 3'd3, "R1 reset leaves lockout");
    drive(0, 1, 3'b101, 3'd3, "R2 open after reset");
    // R7 limit zero acts as one
    drive(1, 0, 3'b000, 3'd0, "R1 reset");
    drive(0, 1, 3'b110, 3'd0, "R7 zero limit single miss locks");
    drive(0, 1, 3'b101, 3'd0, "R5 stays locked");
    // R4 limit seven
    drive(1, 0, 3'b000, 3'd7, "R1 reset");
    for (int i = 0; i < 7; i++) drive(0, 1, 3'b000, 3'd7, "R4 limit seven run");
    // R10 saturation: lower the limit below the count
    drive(1, 0, 3'b000, 3'd7, "R1 reset");
    for (int i = 0; i < 3; i++) drive(0, 1, 3'b011, 3'd7, "R10 build count");
    for (int i = 0; i < 10; i++) drive(0, 1, 3'b011, 3'd2, "R10 saturate no wrap");
    drive(0, 1, 3'b101, 3'd2, "R9 match after saturation");
    drive(0, 1, 3'b011, 3'd2, "R9 count restarted");
    drive(0, 1, 3'b011, 3'd2, "R4 limit two reached");
    drive(0, 0, 3'b000, 3'd2, "R6 idle tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule